// File: doc/BRIEF.md
# Phase Tracking Controller for a Feedback-Interpolated Clock Recovery

This block is the digital half of the slow phase loop in a dual-loop clock recovery circuit. A baud-rate phase detector hands it early/late votes, but only on some cycles, because many data patterns carry no timing information. The controller adds up the votes over an update interval whose length is programmable in reference-clock cycles. At the end of each interval it moves a single phase interpolator code by at most one position. That interpolator sits in the feedback divider path of the frequency-synthesis PLL, so one code change shifts every receive sampling phase together.

Between steps the PLL has to settle before the phase detector can see the effect of a move. For that reason the update interval is meant to be roughly ten times longer than the synthesis loop's response time. The code is a modulo counter that wraps cleanly in both directions, so the recovered phase can slide without limit.

An optional second-order path keeps a saturating frequency estimate. This lets the loop follow a steady ppm offset between the transmit and receive clocks. A tracking-enable input freezes the loop.

Top module: `phase_track_loop`

## Requirements
- R1: After reset the interpolator code `pi_code` is 0.
- R2: With `track_en` high, one update interval spans `interval_len + 1` clock cycles, counted from the first enabled cycle. `pi_code` changes only on the clock edge that closes an interval and holds its value at all other times.
- R3: With `so_en` low, a closing interval moves the code up by one when the net vote count is positive and down by one when it is negative. It leaves the code unchanged when the net count is zero. A vote counts as +1 when `vote_late` is 1 and as -1 when `vote_late` is 0, and only in cycles where `vote_valid` is 1.
- R4: The code moves by at most one position per interval, however many votes arrive.
- R5: The code is 6 bits wide and wraps: up from 63 gives 0, and down from 0 gives 63.
- R6: The vote accumulator saturates at +127 and -128 within an interval, so early votes that follow a saturated run of late votes subtract from 127.
- R7: Every interval starts from an empty accumulator. Votes never carry over into the next interval.
- R8: While `track_en` is low the code holds and votes are ignored. On re-enable, a fresh interval starts with an empty accumulator and a restarted interval count.
- R9: With `so_en` high, a frequency register moves by the interval's vote direction (+1, -1 or 0) at each closing edge and saturates at +7 and -7. The step taken is the sign of the vote direction plus the frequency register value held before that edge.
- R10: While `so_en` is low the frequency register is cleared, so the loop behaves as first order from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| track_en | input | 1 | Tracking enable; low freezes the code |
| so_en | input | 1 | Enables the second-order frequency path |
| interval_len | input | 10 | Update interval length minus one, in clock cycles |
| vote_valid | input | 1 | Phase detector produced a vote this cycle |
| vote_late | input | 1 | Vote polarity: 1 = late (+1), 0 = early (-1) |
| pi_code | output | 6 | Interpolator phase select code |

## Verification
The first-order loop is driven with net-late, net-early, balanced and empty intervals. These show the three step outcomes apart, show that a heavy vote majority still yields a single step, and show that a balanced interval after a late-heavy one does not inherit the earlier count. Steps down from 0 and up from 63 expose wrap errors. A long interval of 150 late votes followed by 140 early votes can only end in a down step if the accumulator saturates. A partial interval that is cut off by disabling tracking, with votes still arriving, shows whether the freeze also clears leftover state and restarts the interval timing. For the second-order path, runs of late intervals, then empty intervals, then early intervals separate an integrating and saturating frequency register from a plain first-order response. Turning `so_en` off afterwards shows that the register is cleared.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'b00,
    DIR_UP   = 2'b01,
    DIR_DN   = 2'b10
  } dir_e;

  function automatic dir_e dir_from(input logic neg, input logic nonzero);
    if (!nonzero)  return DIR_HOLD;
    else if (neg)  return DIR_DN;
    else           return DIR_UP;
  endfunction

endpackage

// File: rtl/pt_tick.sv
module pt_tick #(
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             tick_o
);

  logic [LEN_W-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = en_i && (cnt_q >= len_i);
    cnt_d  = cnt_q;
    if (!en_i || tick_o) cnt_d = '0;
    else                 cnt_d = cnt_q + LEN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pt_vote_acc.sv
module pt_vote_acc
  import pt_pkg::*;
#(
  parameter int ACC_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic vld_i,
  input  logic late_i,
  output dir_e dir_o
);

  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0] acc_q, acc_d, acc_sum;

  always_comb begin
    acc_sum = acc_q;
    if (vld_i && late_i && (acc_q != ACC_MAX))
      acc_sum = acc_q + ACC_W'(1);
    if (vld_i && !late_i && (acc_q != ACC_MIN))
      acc_sum = acc_q - ACC_W'(1);
    dir_o = dir_from(acc_sum[ACC_W-1], |acc_sum);
    if (!en_i || tick_i) acc_d = '0;
    else                 acc_d = acc_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/pt_freq_int.sv
module pt_freq_int
  import pt_pkg::*;
#(
  parameter int FREQ_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  dir_e dir_i,
  output dir_e step_o
);

  localparam int SUM_W = FREQ_W + 2;
  localparam logic signed [FREQ_W-1:0] F_POS = {1'b0, {(FREQ_W-1){1'b1}}};
  localparam logic signed [FREQ_W-1:0] F_NEG = -F_POS;
  localparam logic signed [FREQ_W-1:0] F_BAD = {1'b1, {(FREQ_W-1){1'b0}}};

  logic signed [FREQ_W-1:0] freq_q, freq_d;
  logic signed [SUM_W-1:0]  f_ext, d_ext, total;

  always_comb begin
    f_ext = en_i ? {{2{freq_q[FREQ_W-1]}}, freq_q} : '0;
    case (dir_i)
      DIR_UP:  d_ext = SUM_W'(1);
      DIR_DN:  d_ext = '1;
      default: d_ext = '0;
    endcase
    total  = f_ext + d_ext;
    step_o = dir_from(total[SUM_W-1], |total);

    freq_d = freq_q;
    if (!en_i) begin
      freq_d = '0;
    end else if (tick_i) begin
      if ((dir_i == DIR_UP) && (freq_q != F_POS)) freq_d = freq_q + FREQ_W'(1);
      if ((dir_i == DIR_DN) && (freq_q != F_NEG)) freq_d = freq_q - FREQ_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) freq_q <= '0;
    else        freq_q <= freq_d;
  end

  // R9
  freq_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freq_q != F_BAD);

endmodule

// File: rtl/pt_code_ctr.sv
module pt_code_ctr
  import pt_pkg::*;
#(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  dir_e              step_i,
  output logic [CODE_W-1:0] code_o
);

  logic [CODE_W-1:0] code_q, code_d;

  always_comb begin
    code_d = code_q;
    if (tick_i) begin
      case (step_i)
        DIR_UP:  code_d = code_q + CODE_W'(1);
        DIR_DN:  code_d = code_q - CODE_W'(1);
        default: code_d = code_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;

  // R4
  step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (code_q == $past(code_q)) ||
             (code_q == $past(code_q) + CODE_W'(1)) ||
             (code_q == $past(code_q) - CODE_W'(1)));

endmodule

// File: rtl/phase_track_loop.sv
module phase_track_loop
  import pt_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int ACC_W  = 8,
  parameter int FREQ_W = 4,
  parameter int LEN_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              track_en,
  input  logic              so_en,
  input  logic [LEN_W-1:0]  interval_len,
  input  logic              vote_valid,
  input  logic              vote_late,
  output logic [CODE_W-1:0] pi_code
);

  logic tick;
  dir_e vote_dir;
  dir_e step_dir;

  pt_tick #(.LEN_W(LEN_W)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (track_en),
    .len_i  (interval_len),
    .tick_o (tick)
  );

  pt_vote_acc #(.ACC_W(ACC_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (track_en),
    .tick_i (tick),
    .vld_i  (vote_valid),
    .late_i (vote_late),
    .dir_o  (vote_dir)
  );

  pt_freq_int #(.FREQ_W(FREQ_W)) u_freq (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (so_en),
    .tick_i (tick),
    .dir_i  (vote_dir),
    .step_o (step_dir)
  );

  pt_code_ctr #(.CODE_W(CODE_W)) u_code (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .step_i (step_dir),
    .code_o (pi_code)
  );

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !track_en |=> $stable(pi_code));

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pi_code));

endmodule

// File: tb/tb_phase_track_loop.sv
module tb_phase_track_loop;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       track_en = 1'b0;
  logic       so_en = 1'b0;
  logic [9:0] interval_len = 10'd3;
  logic       vote_valid = 1'b0;
  logic       vote_late = 1'b0;
  logic [5:0] pi_code;

  phase_track_loop dut (
    .clk(clk), .rst_n(rst_n), .track_en(track_en), .so_en(so_en),
    .interval_len(interval_len), .vote_valid(vote_valid),
    .vote_late(vote_late), .pi_code(pi_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  int    ilen = 3;
  int    m_code = 0;
  int    m_freq = 0;
  bit    m_so = 1'b0;
  int    exp_q[$];
  string tag_q[$];

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sgn(int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction

  function automatic void model_step(int late, int early);
    int acc = 0;
    int dir, step;
    for (int i = 0; i < late; i++)  if (acc < 127)  acc++;
    for (int i = 0; i < early; i++) if (acc > -128) acc--;
    dir  = sgn(acc);
    step = sgn((m_so ? m_freq : 0) + dir);
    if (m_so) begin
      m_freq = m_freq + dir;
      if (m_freq > 7)  m_freq = 7;
      if (m_freq < -7) m_freq = -7;
    end else begin
      m_freq = 0;
    end
    m_code = (((m_code + step) % 64) + 64) % 64;
  endfunction

  task automatic start_track(int len, bit so);
    @(negedge clk);
    track_en = 1'b0;
    vote_valid = 1'b0;
    so_en = so;
    interval_len = 10'(len);
    ilen = len;
    m_so = so;
    if (!so) m_freq = 0;
    @(posedge clk);
  endtask

  // Driver: plays one interval, then queues the code expected after it
  task automatic do_interval(int late, int early, string tag);
    for (int i = 0; i <= ilen; i++) begin
      @(negedge clk);
      track_en = 1'b1;
      vote_valid = (i < late + early);
      vote_late = (i < late);
      if (i == ilen) check("R2 held mid-interval", pi_code, m_code);
    end
    @(posedge clk);
    #1;
    vote_valid = 1'b0;
    model_step(late, early);
    exp_q.push_back(m_code);
    tag_q.push_back(tag);
  endtask

  // Monitor: compares queued expectations against the port
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        int    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, pi_code, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset code", pi_code, 0);
    rst_n = 1'b1;

    // first order, 4-cycle intervals
    start_track(3, 1'b0);
    do_interval(1, 2, "R5 wrap down / R3 net early");
    do_interval(3, 0, "R5 wrap up / R3 net late");
    do_interval(4, 0, "R4 single step for four votes");
    do_interval(2, 2, "R7 balanced after late-heavy / R3 hold");
    do_interval(0, 0, "R3 no votes hold");
    do_interval(0, 1, "R3 single early");

    // freeze with a partial interval in flight
    start_track(3, 1'b0);
    repeat (2) begin
      @(negedge clk);
      track_en = 1'b1; vote_valid = 1'b1; vote_late = 1'b1;
    end
    @(negedge clk);
    track_en = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 frozen code", pi_code, m_code);
    do_interval(0, 1, "R8 restart clears partial state");

    // saturation in a long interval
    start_track(299, 1'b0);
    do_interval(150, 140, "R6 accumulator saturation");

    // second order
    start_track(3, 1'b1);
    for (int k = 0; k < 10; k++) do_interval(1, 0, "R9 late integrate");
    for (int k = 0; k < 3; k++)  do_interval(0, 0, "R9 freq drives steps");
    for (int k = 0; k < 10; k++) do_interval(0, 1, "R9 early unwind");

    // back to first order
    start_track(3, 1'b0);
    do_interval(0, 0, "R10 freq cleared");
    do_interval(1, 0, "R10 first order late");

    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule